// File: doc/BRIEF.md
# Five-Valued Gate Implication Step

This block performs one implication step on a single logic gate in the five-valued algebra that fault-oriented test generation uses. Each line carries 0, 1, X (unknown), D (good machine 1, faulty machine 0) or D' (good machine 0, faulty machine 1). The gate may be a buffer, an inverter, or an AND, NAND, OR or NOR with up to `N` inputs. A caller presents the gate kind, the number of connected inputs, the values currently assigned to the inputs and the value currently assigned to the output.

The block answers with a merged result. The output carries the forward-implied value. The inputs carry the backward-implied values. A conflict flag marks a contradiction with a value that was already assigned. Two more flags say whether the gate belongs to the D-frontier, the set of gates a discrepancy could be pushed through next, or to the J-frontier, the set of gates whose output still has to be justified.

A search engine calls the block once per gate it visits. Requests are accepted on a valid/ready handshake and each accepted request yields one registered result.

Top module: `fv_gate_imply`

## Requirements
- R1: A value is coded in 3 bits {known, good, faulty}: 0 = 3'b100, 1 = 3'b111, D = 3'b110, D' = 3'b101. Any code whose known bit (bit 2) is 0 is read as X, and the block produces X as 3'b000. The gate kind codes are 0 buffer, 1 inverter, 2 AND, 3 NAND, 4 OR, 5 NOR. Codes 6 and 7 act as a buffer.
- R2: The controlling value is 0 for AND, NAND, buffer and inverter, and 1 for OR and NOR. The inversion is 1 for NAND, NOR and the inverter. If any connected input holds the plain controlling value c, the forward output is c XOR inversion.
- R3: The forward value is computed separately on the good and faulty components. A component is known when some input component equals c, or when all input components are known and equal to the inverse of c. If either component stays unknown the output is X. So D passes through an inverting gate as D', and AND of D with D' gives 0.
- R4: On a gate with two or more connected inputs, an output holding plain (NOT c) XOR inversion forces every connected input to the plain inverse of c.
- R5: The J-frontier flag is set when a gate with two or more connected inputs has its output at plain c XOR inversion and the forward value of its inputs is X. In that case no input is forced.
- R6: The D-frontier flag is set when a connected input holds D or D', the output is X, and no connected input holds the plain controlling value.
- R7: A buffer, an inverter, or any gate with one connected input is single-input. When its output is known, input 0 is implied to the output value, inverted for an inverting gate, with D and D' included. Such a gate never sets the J-frontier flag.
- R8: The connected count is the fan-in field. A value of 0 is taken as 1 and values above N are taken as N. Buffers and inverters always use 1. Inputs beyond the count neither control nor feed the output, and they are returned bit-for-bit unchanged.
- R9: The conflict flag is set when an implied value is known and differs from a known value already on the same line, whether that line is the output or a connected input.
- R10: A line that already holds a known value keeps it in the result. A line holding X takes its implied value.
- R11: in_ready is low exactly while a result is held and out_ready is low. An accepted request shows its result with out_valid high from the next clock edge. An unconsumed result holds steady. Synchronous reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_kind | input | 3 | Gate kind code |
| in_fanin | input | $clog2(N+1) | Connected input count |
| in_vals | input | 3*N | Current input values, input k at bits 3k+2..3k |
| in_out | input | 3 | Current output value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| res_out | output | 3 | Implied output value |
| res_vals | output | 3*N | Implied input values, same layout as in_vals |
| res_conflict | output | 1 | Contradiction found |
| res_dfront | output | 1 | Gate is on the D-frontier |
| res_jfront | output | 1 | Gate is on the J-frontier |

## Verification
The first directed patterns each isolate one rule. An all-X input set with an unknown output shows that nothing is forced or flagged. A D/D' mix on AND and OR separates component-wise evaluation from a naive five-value table. Output-only assignments on AND and NAND split backward forcing from J-frontier classification. Single-input cases show that D can be implied backward, and clamped fan-in values show that unused inputs are ignored. The remaining patterns pick gate kinds, fan-ins and values from all eight codes pseudo-randomly, so that the X aliases, conflicts and both frontier flags appear in combination. A held result under back-pressure checks that in_ready drops and that the result stays unchanged.

// File: rtl/fv_pkg.sv
package fv_pkg;

    typedef struct packed {
        logic known;
        logic good;
        logic faulty;
    } fv_t;

    localparam fv_t FV_X = 3'b000;

    typedef enum logic [2:0] {
        GK_BUF  = 3'd0,
        GK_INV  = 3'd1,
        GK_AND  = 3'd2,
        GK_NAND = 3'd3,
        GK_OR   = 3'd4,
        GK_NOR  = 3'd5,
        GK_RS6  = 3'd6,
        GK_RS7  = 3'd7
    } gkind_e;

    typedef struct packed {
        logic ctrl;
        logic inv;
        logic single;
    } gattr_t;

    function automatic gattr_t kind_attr(gkind_e k);
        gattr_t a;
        unique case (k)
            GK_INV:  a = '{ctrl: 1'b0, inv: 1'b1, single: 1'b1};
            GK_AND:  a = '{ctrl: 1'b0, inv: 1'b0, single: 1'b0};
            GK_NAND: a = '{ctrl: 1'b0, inv: 1'b1, single: 1'b0};
            GK_OR:   a = '{ctrl: 1'b1, inv: 1'b0, single: 1'b0};
            GK_NOR:  a = '{ctrl: 1'b1, inv: 1'b1, single: 1'b0};
            default: a = '{ctrl: 1'b0, inv: 1'b0, single: 1'b1};
        endcase
        return a;
    endfunction

    function automatic fv_t fv_plain(logic b);
        return '{known: 1'b1, good: b, faulty: b};
    endfunction

    function automatic logic fv_is_plain(fv_t v, logic b);
        return v.known && (v.good == b) && (v.faulty == b);
    endfunction

    function automatic logic fv_is_disc(fv_t v);
        return v.known && (v.good != v.faulty);
    endfunction

    function automatic logic fv_differs(fv_t a, fv_t b);
        return a.known && b.known && ((a.good != b.good) || (a.faulty != b.faulty));
    endfunction

endpackage

// File: rtl/fv_fwd.sv
module fv_fwd
    import fv_pkg::*;
#(
    parameter int N = 8
) (
    input  fv_t [N-1:0] vals,
    input  logic [N-1:0] active,
    input  logic        ctrl,
    input  logic        inv,
    output fv_t         fwd
);

    logic g_hit, g_allnc, f_hit, f_allnc;

    always_comb begin
        g_hit   = 1'b0;
        g_allnc = 1'b1;
        f_hit   = 1'b0;
        f_allnc = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (active[k]) begin
                if (vals[k].known && vals[k].good == ctrl)    g_hit = 1'b1;
                if (!(vals[k].known && vals[k].good != ctrl)) g_allnc = 1'b0;
                if (vals[k].known && vals[k].faulty == ctrl)  f_hit = 1'b1;
                if (!(vals[k].known && vals[k].faulty != ctrl)) f_allnc = 1'b0;
            end
        end
    end

    always_comb begin
        if ((g_hit || g_allnc) && (f_hit || f_allnc)) begin
            fwd.known  = 1'b1;
            fwd.good   = (g_hit ? ctrl : ~ctrl) ^ inv;
            fwd.faulty = (f_hit ? ctrl : ~ctrl) ^ inv;
        end else begin
            fwd = FV_X;
        end
    end

endmodule

// File: rtl/fv_bwd.sv
module fv_bwd
    import fv_pkg::*;
#(
    parameter int N = 8
) (
    input  fv_t [N-1:0] vals,
    input  logic [N-1:0] active,
    input  fv_t         cur_out,
    input  fv_t         fwd,
    input  logic        ctrl,
    input  logic        inv,
    input  logic        single,
    output fv_t [N-1:0] res_vals,
    output fv_t         res_out,
    output logic        conflict,
    output logic        dfront,
    output logic        jfront
);

    logic force_nc;
    fv_t  single_imp;
    fv_t  [N-1:0] implied;
    logic [N-1:0] in_clash;
    logic [N-1:0] in_ctrl;
    logic [N-1:0] in_disc;
    logic out_clash;

    assign force_nc = !single && fv_is_plain(cur_out, (~ctrl) ^ inv);

    always_comb begin
        single_imp = FV_X;
        if (cur_out.known) begin
            single_imp.known  = 1'b1;
            single_imp.good   = cur_out.good ^ inv;
            single_imp.faulty = cur_out.faulty ^ inv;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_line
        always_comb begin
            if (single && k == 0) implied[k] = single_imp;
            else if (force_nc)    implied[k] = fv_plain(~ctrl);
            else                  implied[k] = FV_X;
        end
        assign in_clash[k] = active[k] && fv_differs(vals[k], implied[k]);
        assign in_ctrl[k]  = active[k] && fv_is_plain(vals[k], ctrl);
        assign in_disc[k]  = active[k] && fv_is_disc(vals[k]);
        always_comb begin
            if (!active[k])         res_vals[k] = vals[k];
            else if (vals[k].known) res_vals[k] = vals[k];
            else                    res_vals[k] = implied[k];
        end
    end

    assign out_clash = fv_differs(cur_out, fwd);
    assign res_out   = cur_out.known ? cur_out : fwd;
    assign conflict  = out_clash || (|in_clash);
    assign dfront    = (|in_disc) && !cur_out.known && !(|in_ctrl);
    assign jfront    = !single && fv_is_plain(cur_out, ctrl ^ inv) && !fwd.known;

endmodule

// File: rtl/fv_gate_imply.sv
module fv_gate_imply
    import fv_pkg::*;
#(
    parameter int N = 8,
    localparam int FW = $clog2(N + 1),
    localparam int VW = 3 * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_kind,
    input  logic [FW-1:0] in_fanin,
    input  logic [VW-1:0] in_vals,
    input  logic [2:0]    in_out,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [2:0]    res_out,
    output logic [VW-1:0] res_vals,
    output logic          res_conflict,
    output logic          res_dfront,
    output logic          res_jfront
);

    gattr_t        attr;
    logic [FW-1:0] fan;
    logic          single_eff;
    logic [N-1:0]  active;
    fv_t  [N-1:0]  vin;
    fv_t  [N-1:0]  vres;
    fv_t           cur_out, fwd, nxt_out;
    logic          nxt_conflict, nxt_dfront, nxt_jfront;
    logic          accept;

    assign attr    = kind_attr(gkind_e'(in_kind));
    assign cur_out = fv_t'(in_out);

    always_comb begin
        if (attr.single || in_fanin == '0) fan = FW'(1);
        else if (int'(in_fanin) > N)       fan = FW'(N);
        else                               fan = in_fanin;
    end
    assign single_eff = (fan == FW'(1));

    for (genvar k = 0; k < N; k++) begin : g_in
        assign vin[k]    = fv_t'(in_vals[3*k +: 3]);
        assign active[k] = (k < int'(fan));
    end

    fv_fwd #(.N(N)) u_fwd (
        .vals   (vin),
        .active (active),
        .ctrl   (attr.ctrl),
        .inv    (attr.inv),
        .fwd    (fwd)
    );

    fv_bwd #(.N(N)) u_bwd (
        .vals     (vin),
        .active   (active),
        .cur_out  (cur_out),
        .fwd      (fwd),
        .ctrl     (attr.ctrl),
        .inv      (attr.inv),
        .single   (single_eff),
        .res_vals (vres),
        .res_out  (nxt_out),
        .conflict (nxt_conflict),
        .dfront   (nxt_dfront),
        .jfront   (nxt_jfront)
    );

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            res_out      <= '0;
            res_vals     <= '0;
            res_conflict <= 1'b0;
            res_dfront   <= 1'b0;
            res_jfront   <= 1'b0;
        end else begin
            if (accept) begin
                out_valid    <= 1'b1;
                res_out      <= nxt_out;
                res_vals     <= vres;
                res_conflict <= nxt_conflict;
                res_dfront   <= nxt_dfront;
                res_jfront   <= nxt_jfront;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R11
    accept_gives_result_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R11
    held_result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(res_out) && $stable(res_vals)));

    // R10
    known_output_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_out[2]) |=> (res_out == $past(in_out)));

    // R8
    unused_lines_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_kind == 3'd0) |=> (res_vals[VW-1:3] == $past(in_vals[VW-1:3])));

    // R5 R6
    frontier_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(res_dfront && res_jfront));

endmodule

// File: tb/sim_fv_gate_imply.sv
`timescale 1ns/1ps
module sim_fv_gate_imply;

    localparam int N  = 8;
    localparam int FW = $clog2(N + 1);
    localparam int VW = 3 * N;
    // symbols
    localparam int S0 = 0, S1 = 1, SX = 2, SD = 3, SN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic in_ready, out_valid;
    logic [2:0] in_kind = '0, in_out = '0, res_out;
    logic [FW-1:0] in_fanin = '0;
    logic [VW-1:0] in_vals = '0, res_vals;
    logic res_conflict, res_dfront, res_jfront;

    int checks = 0, fails = 0;
    logic [31:0] seed = 32'h1234_5677;

    always #2.5 clk = ~clk;

    fv_gate_imply #(.N(N)) u0 (
        .clk, .rst, .in_valid, .in_ready, .in_kind, .in_fanin, .in_vals, .in_out,
        .out_valid, .out_ready, .res_out, .res_vals, .res_conflict, .res_dfront, .res_jfront
    );

    initial begin
        #(5.0 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: expected completion, got hang");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    function automatic int dec(logic [2:0] c);
        if (!c[2]) return SX;
        case (c[1:0])
            2'b00: return S0;
            2'b11: return S1;
            2'b10: return SD;
            default: return SN;
        endcase
    endfunction

    function automatic logic [2:0] enc(int s);
        case (s)
            S0: return 3'b100;
            S1: return 3'b111;
            SD: return 3'b110;
            SN: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    function automatic int neg(int s);
        case (s)
            S0: return S1;
            S1: return S0;
            SD: return SN;
            SN: return SD;
            default: return SX;
        endcase
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check_vec(input logic [2:0] kind, input logic [FW-1:0] fanin,
                             input logic [VW-1:0] vals, input logic [2:0] outc, input string tag);
        int  sv[N];
        int  so, fw, fan, c, iv, imp;
        bit  single, any0, any1, anyx, hasd, hasn, conf, anyc, anyd;
        logic [VW-1:0] ev;
        logic [2:0] eo;
        bit  ed, ej;
        // gate attributes per R1 R2
        c  = (kind == 3'd4 || kind == 3'd5) ? 1 : 0;
        iv = (kind == 3'd1 || kind == 3'd3 || kind == 3'd5) ? 1 : 0;
        single = !(kind >= 3'd2 && kind <= 3'd5);
        if (single) fan = 1;
        else if (fanin == 0) fan = 1;
        else if (int'(fanin) > N) fan = N;
        else fan = int'(fanin);
        if (fan == 1) single = 1;
        for (int k = 0; k < N; k++) sv[k] = dec(vals[3*k +: 3]);
        so = dec(outc);
        // forward on symbols (R2 R3): reduce to AND form
        any0 = 0; any1 = 0; anyx = 0; hasd = 0; hasn = 0; anyc = 0; anyd = 0;
        for (int k = 0; k < fan; k++) begin
            int t;
            t = (c == 1) ? neg(sv[k]) : sv[k];
            if (t == S0) any0 = 1;
            if (t == SX) anyx = 1;
            if (t == SD) hasd = 1;
            if (t == SN) hasn = 1;
            if (sv[k] == c) anyc = 1;
            if (sv[k] == SD || sv[k] == SN) anyd = 1;
        end
        if (any0 || (hasd && hasn)) fw = S0;
        else if (anyx) fw = SX;
        else if (hasd) fw = SD;
        else if (hasn) fw = SN;
        else fw = S1;
        if (c == 1) fw = neg(fw);
        if (iv == 1) fw = neg(fw);
        conf = (so != SX && fw != SX && so != fw);
        eo = enc(so != SX ? so : fw);
        ev = vals;
        for (int k = 0; k < fan; k++) begin
            imp = SX;
            if (single) imp = (iv == 1) ? neg(so) : so;
            else if (so == ((c == 1 ? 0 : 1) ^ iv)) imp = (c == 1) ? S0 : S1;
            if (sv[k] != SX && imp != SX && sv[k] != imp) conf = 1;
            ev[3*k +: 3] = enc(sv[k] != SX ? sv[k] : imp);
        end
        ed = anyd && so == SX && !anyc;
        ej = !single && so == (c ^ iv) && fw == SX;
        checks++;
        if (res_out !== eo || res_vals !== ev || res_conflict !== conf ||
            res_dfront !== ed || res_jfront !== ej || out_valid !== 1'b1) begin
            fails++;
            $display("FAIL %s kind=%0d fan=%0d: got out=%b vals=%h c=%b d=%b j=%b v=%b, exp out=%b vals=%h c=%b d=%b j=%b",
                     tag, kind, fanin, res_out, res_vals, res_conflict, res_dfront, res_jfront, out_valid,
                     eo, ev, conf, ed, ej);
        end
    endtask

    task automatic run_vec(input logic [2:0] kind, input logic [FW-1:0] fanin,
                           input logic [VW-1:0] vals, input logic [2:0] outc, input string tag);
        @(negedge clk);
        in_kind = kind; in_fanin = fanin; in_vals = vals; in_out = outc;
        in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check_vec(kind, fanin, vals, outc, tag);
    endtask

    function automatic logic [VW-1:0] fill(logic [2:0] code);
        logic [VW-1:0] v;
        for (int k = 0; k < N; k++) v[3*k +: 3] = code;
        return v;
    endfunction

    initial begin
        logic [VW-1:0] v;
        logic [2:0] hold_out;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R11 reset: got valid=%b ready=%b, exp 0 1", out_valid, in_ready);
        end
        // R1 all-X on every kind, nothing forced
        for (int k = 0; k < 8; k++) run_vec(3'(k), FW'(4), fill(3'b000), 3'b000, "R1 all-X");
        // R1 X aliases with known bit clear
        run_vec(3'd2, FW'(3), {15'd0, 3'b100, 3'b011, 3'b010}, 3'b001, "R1 X alias");
        // R3 AND of D and D' gives 0 even with X
        run_vec(3'd2, FW'(3), {15'd0, 3'b000, 3'b101, 3'b110}, 3'b000, "R3 D&D'");
        // R3 NAND passes D as D'
        run_vec(3'd3, FW'(3), {15'd0, 3'b111, 3'b110, 3'b111}, 3'b000, "R3 D through NAND");
        // R2 OR with a controlling 1
        run_vec(3'd4, FW'(3), {15'd0, 3'b000, 3'b111, 3'b110}, 3'b000, "R2 OR ctrl");
        // R4 AND output 1 forces inputs
        run_vec(3'd2, FW'(5), fill(3'b000), 3'b111, "R4 AND force");
        // R4 NOR output 1 forces 0s
        run_vec(3'd5, FW'(8), fill(3'b000), 3'b111, "R4 NOR force");
        // R5 AND output 0 with X inputs
        run_vec(3'd2, FW'(4), fill(3'b000), 3'b100, "R5 J-frontier");
        // R6 D-frontier on OR with 0 side inputs
        run_vec(3'd4, FW'(3), {15'd0, 3'b000, 3'b100, 3'b110}, 3'b000, "R6 D-frontier");
        // R7 inverter output D implies D'
        run_vec(3'd1, FW'(5), fill(3'b000), 3'b110, "R7 inverter back");
        // R7 AND with one input, output 0
        run_vec(3'd2, FW'(1), fill(3'b000), 3'b100, "R7 fan-in one");
        // R8 ignored controlling input, fanin 0 and clamp
        run_vec(3'd2, FW'(2), {18'h0, 3'b111, 3'b111} | (fill(3'b100) & ~24'h3F), 3'b000, "R8 ignored");
        run_vec(3'd3, FW'(0), fill(3'b111), 3'b000, "R8 fanin zero");
        run_vec(3'd4, FW'(15), fill(3'b100), 3'b000, "R8 fanin clamp");
        // R9 conflicts on input and output
        run_vec(3'd2, FW'(3), {15'd0, 3'b000, 3'b110, 3'b000}, 3'b111, "R9 input clash");
        run_vec(3'd2, FW'(2), {18'd0, 3'b100, 3'b111}, 3'b111, "R9 output clash");
        // R10 R2 R3 R4 R5 R6 R7 R8 R9 random sweep
        for (int t = 0; t < 6000; t++) begin
            logic [31:0] r;
            r = rnd();
            for (int k = 0; k < N; k++) begin
                logic [31:0] q;
                q = rnd();
                case (q[2:0])
                    3'd0: v[3*k +: 3] = 3'b100;
                    3'd1: v[3*k +: 3] = 3'b111;
                    3'd2: v[3*k +: 3] = 3'b110;
                    3'd3: v[3*k +: 3] = 3'b101;
                    3'd4, 3'd5: v[3*k +: 3] = 3'b000;
                    default: v[3*k +: 3] = {1'b0, q[4:3]};
                endcase
            end
            hold_out = r[9] ? {1'b0, r[11:10]} : {r[8], (r[7:6] == 2'b00) ? 2'b00 : r[7:6]};
            run_vec(r[2:0], r[6:3], v, hold_out, "R10 random");
        end
        // R11 back-pressure: result held, in_ready low
        @(negedge clk);
        in_kind = 3'd2; in_fanin = FW'(2); in_vals = fill(3'b111); in_out = 3'b000;
        in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        #1 in_kind = 3'd4; in_vals = fill(3'b100);
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b0 || out_valid !== 1'b1 || res_out !== 3'b111) begin
            fails++;
            $display("FAIL R11 stall: got ready=%b valid=%b out=%b, exp 0 1 111", in_ready, out_valid, res_out);
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || res_out !== 3'b111) begin
            fails++;
            $display("FAIL R11 hold: got valid=%b out=%b, exp 1 111", out_valid, res_out);
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check_vec(3'd4, FW'(2), fill(3'b100), 3'b000, "R11 after release");
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 drain: got valid=%b, exp 0", out_valid);
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule